// File: doc/BRIEF.md
# Debug Register Access Scan Chain

This block is a test-access data-register chain that gives an external debugger read and write access to the internal registers of a trace capture unit. The debugger shifts a frame serially through the chain. Each frame carries a data word, a register address and a direction flag. The chain turns each frame into one access on a simple parallel register bus.

Writes complete in the scan that carries them. Reads are pipelined by one scan. The address of a read is latched when the frame is applied. The register contents are fetched at the start of the next scan and shifted out in that scan. Because some registers have read side effects, each capture issues exactly one read strobe. A burst of reads from a self-advancing register should therefore end with a frame that names a register without side effects. The TAP state machine and the instruction decode sit outside this block. They provide per-state strobes and a select line that is asserted while this chain's instruction is active.

Top module: `jtag_reg_chain`

## Requirements
- R1: While `trst_n` is low, `tdo`, `bus_we` and `bus_re` are 0. After reset, the latched read address is 0, so the first capture reads register 0.
- R2: With `chain_sel` high and `tap_shift` high, the chain shifts one bit per clock toward `tdo`. `tdo` shows bit 0 of the chain. `tdi` enters at the most significant bit, so bits come out least significant first.
- R3: The frame is DATA_W+ADDR_W+1 bits wide (40 by default). The data field is at bits [31:0], the address at bits [38:32] and the direction flag at bit 39.
- R4: In the `tap_update` cycle of a frame whose flag is 1 and whose address is in range, `bus_we` pulses for exactly that one cycle. In that cycle, `bus_addr` carries the frame address and `bus_wdata` carries the frame data.
- R5: A frame whose flag is 0 causes no bus strobe at `tap_update`. Its address becomes the latched read address. A write frame leaves the latched read address unchanged.
- R6: In a `tap_capture` cycle, `bus_re` pulses once, with `bus_addr` equal to the latched read address. The chain then loads `bus_rdata` into the data field, the latched address into the address field, and 0 into the flag bit.
- R7: The data for a read address appears in the data field of the scan that follows the scan that presented the address, and not in the same scan.
- R8: Addresses at or above NUM_REGS (9 by default) produce no bus strobe. A write to such an address has no effect, and a read of such an address captures 0 in the data field.
- R9: While `chain_sel` is low, capture, shift and update have no effect, no strobe is issued and `tdo` is 0.
- R10: `bus_we` and `bus_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset |
| chain_sel | input | 1 | High while this chain's instruction is selected |
| tap_capture | input | 1 | TAP is in the capture state of the data register |
| tap_shift | input | 1 | TAP is in the shift state of the data register |
| tap_update | input | 1 | TAP is in the update state of the data register |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (bit 0 of the chain) |
| bus_addr | output | ADDR_W | Register bus address |
| bus_wdata | output | DATA_W | Register bus write data |
| bus_we | output | 1 | Register write strobe, one cycle |
| bus_re | output | 1 | Register read strobe, one cycle |
| bus_rdata | input | DATA_W | Register read data, combinational from bus_addr |

## Verification
The bench connects a register model in which one register returns successive buffer entries and advances a pointer on every read strobe. A design that fetched read data in the same scan, or that issued a second read per capture, would return the wrong entry or skip entries. The bench also applies frames to addresses past the last register. A design that did not check the range would corrupt the model or return stale data. A scan with the select line low and an 80-bit shift with no capture in between target two further faults: an update that is not gated by the select line, and a chain that reverses the bit order.

// File: rtl/jtag_reg_chain_pkg.sv
package jtag_reg_chain_pkg;

    // Kind of bus access a chain event produces
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    // Default geometry of the access frame
    localparam int DEF_DATA_W   = 32;
    localparam int DEF_ADDR_W   = 7;
    localparam int DEF_NUM_REGS = 9;

endpackage

// File: rtl/jtag_reg_chain_range.sv
module jtag_reg_chain_range #(
    parameter int ADDR_W   = 7,
    parameter int NUM_REGS = 9
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_range
);
    localparam int EXT_W = (ADDR_W < 32) ? 32 : ADDR_W + 1;

    logic [EXT_W-1:0] addr_ext;

    always_comb begin
        addr_ext = EXT_W'(addr);
        in_range = (addr_ext < EXT_W'(NUM_REGS));
    end
endmodule

// File: rtl/jtag_reg_chain_shift.sv
module jtag_reg_chain_shift #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         shift_en,
    input  logic         sin,
    output logic [W-1:0] frame,
    output logic         sout
);
    typedef struct packed {
        logic [W-1:0] sr;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_en) begin
            st_d.sr = load_val;
        end else if (shift_en) begin
            st_d.sr = {sin, st_q.sr[W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame = st_q.sr;
    assign sout  = st_q.sr[0];

    // R2: each shift moves the chain one place toward the output and takes tdi at the top
    p_shift_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !load_en) |=> (st_q.sr[W-2:0] == $past(st_q.sr[W-1:1])) && (st_q.sr[W-1] == $past(sin)));

    // R6: capture loads the presented value
    p_capture_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (st_q.sr == $past(load_val)));
endmodule

// File: rtl/jtag_reg_chain_access.sv
module jtag_reg_chain_access
    import jtag_reg_chain_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 7,
    parameter int NUM_REGS = 9
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       active,
    input  logic                       capture,
    input  logic                       update,
    input  logic [DATA_W+ADDR_W:0]     frame,
    input  logic [DATA_W-1:0]          rdata,
    output logic [DATA_W+ADDR_W:0]     cap_val,
    output logic [ADDR_W-1:0]          bus_addr,
    output logic [DATA_W-1:0]          bus_wdata,
    output logic                       bus_we,
    output logic                       bus_re
);
    localparam int FRAME_W = DATA_W + ADDR_W + 1;
    localparam int FLAG_B  = FRAME_W - 1;

    typedef struct packed {
        logic [ADDR_W-1:0] pend;
    } state_t;

    state_t            st_d, st_q;
    logic [ADDR_W-1:0] frm_addr;
    logic [DATA_W-1:0] frm_data;
    logic              frm_flag;
    logic              frm_ok;
    logic              pend_ok;
    acc_kind_e         kind;

    assign frm_data = frame[DATA_W-1:0];
    assign frm_addr = frame[DATA_W +: ADDR_W];
    assign frm_flag = frame[FLAG_B];

    jtag_reg_chain_range #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_rng_frame (
        .addr     (frm_addr),
        .in_range (frm_ok)
    );

    jtag_reg_chain_range #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_rng_pend (
        .addr     (st_q.pend),
        .in_range (pend_ok)
    );

    always_comb begin
        st_d = st_q;
        kind = ACC_IDLE;
        if (active && capture && pend_ok) begin
            kind = ACC_READ;
        end else if (active && update && frm_flag && frm_ok) begin
            kind = ACC_WRITE;
        end
        if (active && update && !frm_flag) begin
            st_d.pend = frm_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_we    = (kind == ACC_WRITE);
        bus_re    = (kind == ACC_READ);
        bus_addr  = (active && update) ? frm_addr : st_q.pend;
        bus_wdata = frm_data;
        cap_val   = {1'b0, st_q.pend, (kind == ACC_READ) ? rdata : {DATA_W{1'b0}}};
    end

    // R5: a read frame's address becomes the latched read address
    p_read_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && update && !frm_flag) |=> (st_q.pend == $past(frm_addr)));

    // R5: a write frame leaves the latched read address alone
    p_write_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && update && frm_flag) |=> $stable(st_q.pend));

    // R8: no strobe reaches an unimplemented address
    p_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we || bus_re) |-> (32'(bus_addr) < NUM_REGS));
endmodule

// File: rtl/jtag_reg_chain.sv
module jtag_reg_chain
    import jtag_reg_chain_pkg::*;
#(
    parameter int DATA_W   = DEF_DATA_W,
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int NUM_REGS = DEF_NUM_REGS
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              chain_sel,
    input  logic              tap_capture,
    input  logic              tap_shift,
    input  logic              tap_update,
    input  logic              tdi,
    output logic              tdo,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_we,
    output logic              bus_re,
    input  logic [DATA_W-1:0] bus_rdata
);
    localparam int FRAME_W = DATA_W + ADDR_W + 1;

    logic               active;
    logic [FRAME_W-1:0] frame;
    logic [FRAME_W-1:0] cap_val;
    logic               sout;

    assign active = chain_sel && trst_n;

    jtag_reg_chain_shift #(.W(FRAME_W)) u_shift (
        .clk      (tck),
        .rst_n    (trst_n),
        .load_en  (active && tap_capture),
        .load_val (cap_val),
        .shift_en (active && tap_shift),
        .sin      (tdi),
        .frame    (frame),
        .sout     (sout)
    );

    jtag_reg_chain_access #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS)
    ) u_access (
        .clk       (tck),
        .rst_n     (trst_n),
        .active    (active),
        .capture   (tap_capture),
        .update    (tap_update),
        .frame     (frame),
        .rdata     (bus_rdata),
        .cap_val   (cap_val),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re)
    );

    assign tdo = active ? sout : 1'b0;

    // R10: read and write strobes are mutually exclusive
    p_strobe_excl_r10: assert property (@(posedge tck) disable iff (!trst_n)
        !(bus_we && bus_re));

    // R4: a write strobe only in a selected update cycle, and only for one cycle
    p_we_update_r4: assert property (@(posedge tck) disable iff (!trst_n)
        bus_we |-> (chain_sel && tap_update));

    p_we_single_r4: assert property (@(posedge tck) disable iff (!trst_n)
        bus_we |=> !bus_we);

    // R6: a read strobe only in a selected capture cycle
    p_re_capture_r6: assert property (@(posedge tck) disable iff (!trst_n)
        bus_re |-> (chain_sel && tap_capture));

    // R9: a deselected chain drives tdo low
    p_desel_tdo_r9: assert property (@(posedge tck) disable iff (!trst_n)
        !chain_sel |-> !tdo);
endmodule

// File: tb/jtag_reg_chain_bench.sv
module jtag_reg_chain_bench;
    localparam int DW = 32;
    localparam int AW = 7;
    localparam int FW = DW + AW + 1;
    localparam int NV = 16;
    localparam logic [31:0] ID_VAL = 32'h1234_5ABC;

    logic          tck = 1'b0;
    logic          trst_n = 1'b0;
    logic          chain_sel = 1'b0;
    logic          tap_capture = 1'b0;
    logic          tap_shift = 1'b0;
    logic          tap_update = 1'b0;
    logic          tdi = 1'b0;
    logic          tdo;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_we;
    logic          bus_re;
    logic [DW-1:0] bus_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4ns tck = ~tck;

    jtag_reg_chain u_jtag_reg_chain (
        .tck         (tck),
        .trst_n      (trst_n),
        .chain_sel   (chain_sel),
        .tap_capture (tap_capture),
        .tap_shift   (tap_shift),
        .tap_update  (tap_update),
        .tdi         (tdi),
        .tdo         (tdo),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_we      (bus_we),
        .bus_re      (bus_re),
        .bus_rdata   (bus_rdata)
    );

    // Register model: 0 id, 1 depth, 2 width, 3/6/7/8 scratch, 4 buffer data (advances), 5 pointer
    logic [31:0] scratch [9];
    logic [3:0]  rptr;
    int          wr_cnt, rd_cnt;
    logic [AW-1:0] last_wa;
    logic [DW-1:0] last_wd;

    function automatic logic [31:0] ram_val(input logic [3:0] i);
        return 32'hA000_0000 + 32'(i) * 32'd17;
    endfunction

    always_comb begin
        case (bus_addr)
            7'd0:    bus_rdata = ID_VAL;
            7'd1:    bus_rdata = 32'd16;
            7'd2:    bus_rdata = 32'd32;
            7'd4:    bus_rdata = ram_val(rptr);
            7'd5:    bus_rdata = {28'd0, rptr};
            7'd3, 7'd6, 7'd7, 7'd8: bus_rdata = scratch[bus_addr[3:0]];
            default: bus_rdata = 32'd0;
        endcase
    end

    always @(posedge tck) begin
        if (bus_we) begin
            wr_cnt  <= wr_cnt + 1;
            last_wa <= bus_addr;
            last_wd <= bus_wdata;
            if (bus_addr == 7'd5) rptr <= bus_wdata[3:0];
            else if (bus_addr inside {7'd3, 7'd6, 7'd7, 7'd8}) scratch[bus_addr[3:0]] <= bus_wdata;
        end
        if (bus_re) begin
            rd_cnt <= rd_cnt + 1;
            if (bus_addr == 7'd4) rptr <= rptr + 4'd1;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One full scan: capture, FW shifts, update. Returns the bits seen on tdo.
    task automatic scan(input logic flag, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic [FW-1:0] got);
        logic [FW-1:0] out_v;
        out_v = {flag, a, d};
        @(negedge tck);
        tap_capture = 1'b1;
        for (int i = 0; i < FW; i++) begin
            @(negedge tck);
            tap_capture = 1'b0;
            tap_shift   = 1'b1;
            tdi         = out_v[i];
            #1ns;
            got[i] = tdo;
        end
        @(negedge tck);
        tap_shift  = 1'b0;
        tap_update = 1'b1;
        @(negedge tck);
        tap_update = 1'b0;
    endtask

    // Vector: flag, addr, data, expected captured data, expected captured address field
    localparam logic [78:0] VEC [NV] = '{
        {1'b0, 7'd1,   32'h0,         32'h1234_5ABC, 7'd0},
        {1'b0, 7'd2,   32'h0,         32'd16,        7'd1},
        {1'b1, 7'd3,   32'hDEAD_BEEF, 32'd32,        7'd2},
        {1'b0, 7'd3,   32'h0,         32'd32,        7'd2},
        {1'b1, 7'd5,   32'd3,         32'hDEAD_BEEF, 7'd3},
        {1'b0, 7'd4,   32'h0,         32'hDEAD_BEEF, 7'd3},
        {1'b0, 7'd4,   32'h0,         32'hA000_0033, 7'd4},
        {1'b0, 7'd0,   32'h0,         32'hA000_0044, 7'd4},
        {1'b0, 7'd5,   32'h0,         32'h1234_5ABC, 7'd0},
        {1'b0, 7'd0,   32'h0,         32'd5,         7'd5},
        {1'b0, 7'd100, 32'h0,         32'h1234_5ABC, 7'd0},
        {1'b0, 7'd0,   32'h0,         32'd0,         7'd100},
        {1'b1, 7'd120, 32'hFFFF_FFFF, 32'h1234_5ABC, 7'd0},
        {1'b0, 7'd8,   32'h0,         32'h1234_5ABC, 7'd0},
        {1'b1, 7'd8,   32'h0000_00AA, 32'd0,         7'd8},
        {1'b0, 7'd0,   32'h0,         32'h0000_00AA, 7'd8}
    };

    initial begin
        logic [FW-1:0] got;
        int wr0, rd0;
        for (int i = 0; i < 9; i++) scratch[i] = 32'd0;
        rptr = 4'd0; wr_cnt = 0; rd_cnt = 0; last_wa = '0; last_wd = '0;

        // R1: quiet during reset even with state strobes present
        chain_sel = 1'b1; tap_capture = 1'b1; tap_update = 1'b1;
        repeat (3) @(negedge tck);
        #1ns;
        chk("R1 tdo in reset", 64'(tdo), 64'd0);
        chk("R1 strobes in reset", 64'({bus_we, bus_re}), 64'd0);
        tap_capture = 1'b0; tap_update = 1'b0;
        @(negedge tck);
        trst_n = 1'b1;
        @(negedge tck);

        // Table: R3 R6 R7 R8 and the buffer pointer read side effect
        for (int v = 0; v < NV; v++) begin
            scan(VEC[v][78], VEC[v][77:71], VEC[v][70:39], got);
            chk($sformatf("R7 vector %0d data", v), 64'(got[31:0]), 64'(VEC[v][38:7]));
            chk($sformatf("R3 R6 vector %0d addr/flag", v), 64'(got[39:32]), 64'({1'b0, VEC[v][6:0]}));
        end
        chk("R6 read strobe count", 64'(rd_cnt), 64'd15);
        chk("R8 write strobe count", 64'(wr_cnt), 64'd3);
        chk("R4 last write addr/data", {25'd0, last_wa, last_wd}, {25'd0, 7'd8, 32'h0000_00AA});
        chk("R6 one pointer step per read", 64'(rptr), 64'd5);

        // R9: deselected scan does nothing
        wr0 = wr_cnt; rd0 = rd_cnt;
        chain_sel = 1'b0;
        scan(1'b1, 7'd3, 32'h0000_0055, got);
        chk("R9 tdo low when deselected", 64'(got), 64'd0);
        chk("R9 no strobes when deselected", 64'(wr_cnt - wr0 + rd_cnt - rd0), 64'd0);
        chain_sel = 1'b1;
        scan(1'b0, 7'd3, 32'h0, got);
        scan(1'b0, 7'd0, 32'h0, got);
        chk("R9 register 3 untouched", 64'(got[31:0]), 64'hDEAD_BEEF);

        // R2: capture then 80 shifts; second 40 outputs are the first 40 inputs in order
        begin
            logic [FW-1:0] p1, p2, o1, o2;
            p1 = {1'b1, 7'd55, 32'h1357_9BDF};
            p2 = {1'b0, 7'd2, 32'h0};
            @(negedge tck);
            tap_capture = 1'b1;
            for (int i = 0; i < 2 * FW; i++) begin
                @(negedge tck);
                tap_capture = 1'b0;
                tap_shift   = 1'b1;
                tdi = (i < FW) ? p1[i] : p2[i - FW];
                #1ns;
                if (i < FW) o1[i] = tdo; else o2[i - FW] = tdo;
            end
            @(negedge tck);
            tap_shift = 1'b0; tap_update = 1'b1;
            @(negedge tck);
            tap_update = 1'b0;
            chk("R2 first pass is captured frame", 64'(o1), 64'({1'b0, 7'd0, ID_VAL}));
            chk("R2 bits emerge lsb first", 64'(o2), 64'(p1));
            scan(1'b0, 7'd0, 32'h0, got);
            chk("R5 R7 last applied read frame wins", 64'(got[38:0]), 64'({7'd2, 32'd32}));
        end

        // R10 and R4: write strobe pulses for one cycle only, never with read
        wr0 = wr_cnt;
        scan(1'b1, 7'd6, 32'h0BAD_CAFE, got);
        chk("R4 R10 single write strobe", 64'(wr_cnt - wr0), 64'd1);
        scan(1'b0, 7'd6, 32'h0, got);
        scan(1'b0, 7'd0, 32'h0, got);
        chk("R4 written value reads back", 64'(got[31:0]), 64'h0BAD_CAFE);

        // R1: mid-run reset clears the latched read address
        scan(1'b0, 7'd2, 32'h0, got);
        @(negedge tck); trst_n = 1'b0;
        @(negedge tck); trst_n = 1'b1;
        scan(1'b0, 7'd0, 32'h0, got);
        chk("R1 read address returns to 0", 64'(got[39:0]), 64'({8'd0, ID_VAL}));

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(8ns * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule